// File: doc/BRIEF.md
# Interrupt and Wake-up Controller

This block gathers the interrupt sources of a small 8-bit microcontroller and turns them into one interrupt request for the CPU and a wake-up pulse that ends sleep. There are three sources. The first is a one-cycle timer overflow pulse that is already synchronous to the clock. The second is an external interrupt pin, and its active edge is selectable. The third is a level change on any port B pin that a per-pin mask admits.

Software reaches three registers through a simple write/read bus:
- address 0 holds the sticky event flags;
- address 1 holds the source enables and the global enable;
- address 2 holds the port B change mask.

The external pin and the port B pins pass through a two-stage synchronizer before edge or change detection. The reset input is asserted asynchronously and released through a two-flop synchronizer, so the registers leave reset two clock edges after `rst_n` rises.

During sleep, only the external-pin event and the port-change event can produce the wake pulse. The timer can only interrupt.

Top module: `iwc_ctrl`

## Requirements
- R1: After reset the flag register reads 0x00, the enable register reads 0x78, the mask register reads 0x00, and `irq` and `wake` are 0.
- R2: A `tmr_ovf` pulse sets flag bit 0 at the next clock edge, whatever the enable bits hold.
- R3: With `edge_sel`=1 a rising edge on `ext_pin` sets flag bit 2, and with `edge_sel`=0 a falling edge sets it. The flag appears three clock edges after the pin changes. The edge of the opposite polarity is ignored.
- R4: A level change on port B pin n sets flag bit 1 (three edges later) only when mask bit n is 1. Changes on pins whose mask bit is 0 leave the flag clear.
- R5: Reads return the following, with any write to address 3 ignored:
  - address 0: flags in bits 2..0 and 0 in bits 7..3;
  - address 1: global enable in bit 7, 1 in bits 6..3, and source enables in bits 2 (pin), 1 (port change) and 0 (timer);
  - address 2: the mask;
  - address 3: 0x00.
- R6: A write of 0 to a flag bit clears it. A hardware event for that bit in the same cycle wins, and the flag stays 1.
- R7: `irq` is 1 exactly when the global enable is 1 and some flag is 1 whose own enable bit is 1.
- R8: While `sleep_mode` is 1, an enabled external-pin event or an enabled, unmasked port-change event gives a one-cycle `wake` pulse one edge after detection. This holds whatever the global enable is. A timer overflow never wakes the device, and no pulse occurs outside sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_ovf | input | 1 | Synchronous timer overflow pulse |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| pb_pins | input | PB_W | Asynchronous port B levels |
| edge_sel | input | 1 | External pin edge: 1 rising, 0 falling |
| sleep_mode | input | 1 | CPU is sleeping |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on address) |
| irq | output | 1 | Interrupt request to the CPU |
| wake | output | 1 | One-cycle wake-up pulse |

## Verification
A software write that clears a flag can land in the same cycle as a hardware event for that flag. The bench provokes this by asserting `tmr_ovf` during the very clock edge of a zero write to the flag register. It judges the result on a later read, where flag bit 0 must still be 1. The second same-cycle case is a port change during sleep: it both sets the port-change flag and raises `wake`. With the global enable off, the bench expects `wake` high, the flag set and `irq` low, all sampled in the same cycle.

// File: rtl/iwc_pkg.sv
package iwc_pkg;
  localparam int DATA_W = 8;
  localparam int NSRC   = 3;
  localparam int GIE_B  = DATA_W - 1;

  typedef enum logic [1:0] {
    SRC_TMR = 2'd0,
    SRC_PBC = 2'd1,
    SRC_EXT = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    RA_FLAG = 2'd0,
    RA_ENAB = 2'd1,
    RA_MASK = 2'd2,
    RA_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/iwc_sync.sv
module iwc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_n;

  always_comb begin
    stg_n[0] = d;
    for (int i = 1; i < STAGES; i++) stg_n[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_n;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/iwc_detect.sv
module iwc_detect #(
  parameter int PB_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_s,
  input  logic [PB_W-1:0] pb_s,
  input  logic            edge_sel,
  input  logic [PB_W-1:0] pb_mask,
  output logic            ext_evt,
  output logic            pb_evt
);
  logic            ext_prev;
  logic [PB_W-1:0] pb_prev;
  logic [PB_W-1:0] pin_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_prev <= 1'b0;
      pb_prev  <= '0;
    end else begin
      ext_prev <= ext_s;
      pb_prev  <= pb_s;
    end
  end

  for (genvar g = 0; g < PB_W; g++) begin : g_pin
    assign pin_hit[g] = pb_mask[g] & (pb_s[g] ^ pb_prev[g]);
  end

  assign pb_evt  = |pin_hit;
  assign ext_evt = edge_sel ? (ext_s & ~ext_prev) : (~ext_s & ext_prev);
endmodule

// File: rtl/iwc_regs.sv
module iwc_regs
  import iwc_pkg::*;
#(
  parameter int PB_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [NSRC-1:0]   set_vec,
  output logic [NSRC-1:0]   flag_q,
  output logic [NSRC-1:0]   en_q,
  output logic              gie_q,
  output logic [PB_W-1:0]   mask_q
);
  localparam int PAD_W = DATA_W - 1 - NSRC;

  logic [NSRC-1:0] flag_n, en_n;
  logic            gie_n;
  logic [PB_W-1:0] mask_n;
  logic            wr_flag, wr_enab, wr_mask;

  assign wr_flag = wr_en && (addr == RA_FLAG);
  assign wr_enab = wr_en && (addr == RA_ENAB);
  assign wr_mask = wr_en && (addr == RA_MASK);

  always_comb begin
    flag_n = (wr_flag ? wdata[NSRC-1:0] : flag_q) | set_vec;
    en_n   = wr_enab ? wdata[NSRC-1:0] : en_q;
    gie_n  = wr_enab ? wdata[GIE_B]    : gie_q;
    mask_n = wr_mask ? wdata[PB_W-1:0] : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
      gie_q  <= 1'b0;
      mask_q <= '0;
    end else begin
      flag_q <= flag_n;
      en_q   <= en_n;
      gie_q  <= gie_n;
      mask_q <= mask_n;
    end
  end

  always_comb begin
    unique case (addr)
      RA_FLAG: rdata = DATA_W'(flag_q);
      RA_ENAB: rdata = {gie_q, {PAD_W{1'b1}}, en_q};
      RA_MASK: rdata = DATA_W'(mask_q);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/iwc_ctrl.sv
module iwc_ctrl
  import iwc_pkg::*;
#(
  parameter int PB_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_ovf,
  input  logic              ext_pin,
  input  logic [PB_W-1:0]   pb_pins,
  input  logic              edge_sel,
  input  logic              sleep_mode,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wake
);
  logic [1:0]      rst_pipe;
  logic            rst_sn;
  logic            ext_s;
  logic [PB_W-1:0] pb_s;
  logic            ext_evt, pb_evt;
  logic [NSRC-1:0] set_vec, flag_q, en_q;
  logic            gie;
  logic [PB_W-1:0] mask_q;
  logic            wake_n, wake_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  iwc_sync #(.W(1 + PB_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     ({ext_pin, pb_pins}),
    .q     ({ext_s, pb_s})
  );

  iwc_detect #(.PB_W(PB_W)) u_det (
    .clk      (clk),
    .rst_n    (rst_sn),
    .ext_s    (ext_s),
    .pb_s     (pb_s),
    .edge_sel (edge_sel),
    .pb_mask  (mask_q),
    .ext_evt  (ext_evt),
    .pb_evt   (pb_evt)
  );

  always_comb begin
    set_vec          = '0;
    set_vec[SRC_TMR] = tmr_ovf;
    set_vec[SRC_PBC] = pb_evt;
    set_vec[SRC_EXT] = ext_evt;
  end

  iwc_regs #(.PB_W(PB_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sn),
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .rdata   (bus_rdata),
    .set_vec (set_vec),
    .flag_q  (flag_q),
    .en_q    (en_q),
    .gie_q   (gie),
    .mask_q  (mask_q)
  );

  assign irq = gie & |(flag_q & en_q);

  assign wake_n = sleep_mode &
                  ((ext_evt & en_q[SRC_EXT]) | (pb_evt & en_q[SRC_PBC]));

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) wake_q <= 1'b0;
    else         wake_q <= wake_n;
  end
  assign wake = wake_q;
endmodule

// File: rtl/iwc_ctrl_chk.sv
module iwc_ctrl_chk (
  input logic       clk,
  input logic       rst_sn,
  input logic       tmr_ovf,
  input logic       sleep_mode,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic       irq,
  input logic       wake,
  input logic [2:0] flag_q,
  input logic       gie,
  input logic       ext_evt,
  input logic       pb_evt
);
  p_tmr_sets_r2: assert property (@(posedge clk) disable iff (!rst_sn)
    tmr_ovf |=> flag_q[0]);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_wr && bus_addr == 2'd0 && !bus_wdata[0] && !tmr_ovf) |=> !flag_q[0]);

  p_gie_gate_r7: assert property (@(posedge clk) disable iff (!rst_sn)
    !gie |-> !irq);

  p_wake_sleep_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    wake |-> $past(sleep_mode));

  p_wake_src_r8: assert property (@(posedge clk) disable iff (!rst_sn)
    wake |-> $past(ext_evt || pb_evt));

  p_flag_pad_r5: assert property (@(posedge clk) disable iff (!rst_sn)
    (bus_addr == 2'd0) |-> (bus_rdata[7:3] == 5'd0));
endmodule

bind iwc_ctrl iwc_ctrl_chk u_chk (
  .clk        (clk),
  .rst_sn     (rst_sn),
  .tmr_ovf    (tmr_ovf),
  .sleep_mode (sleep_mode),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .irq        (irq),
  .wake       (wake),
  .flag_q     (flag_q),
  .gie        (gie),
  .ext_evt    (ext_evt),
  .pb_evt     (pb_evt)
);

// File: tb/iwc_ctrl_bench.sv
module iwc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tmr_ovf = 1'b0;
  logic       ext_pin = 1'b0;
  logic [7:0] pb_pins = 8'h00;
  logic       edge_sel = 1'b1;
  logic       sleep_mode = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq, wake;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] v;

  always #10 clk = ~clk;

  iwc_ctrl u_iwc_ctrl (
    .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_pin(ext_pin),
    .pb_pins(pb_pins), .edge_sel(edge_sel), .sleep_mode(sleep_mode),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
  );

  // {addr, write data, expected read}
  localparam logic [17:0] VEC [7] = '{
    {2'd1, 8'h00, 8'h78},
    {2'd1, 8'hFF, 8'hFF},
    {2'd1, 8'h05, 8'h7D},
    {2'd2, 8'hA5, 8'hA5},
    {2'd2, 8'h00, 8'h00},
    {2'd3, 8'h55, 8'h00},
    {2'd1, 8'h00, 8'h78}
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    tick(1);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    // R1 reset state
    rd(2'd0, v); chk("R1 flags", v, 8'h00);
    rd(2'd1, v); chk("R1 enables", v, 8'h78);
    rd(2'd2, v); chk("R1 mask", v, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 wake", {7'd0, wake}, 8'h00);

    // R5 register map vectors
    for (int i = 0; i < 7; i++) begin
      wr(VEC[i][17:16], VEC[i][15:8]);
      rd(VEC[i][17:16], v);
      chk("R5 readback", v, VEC[i][7:0]);
    end

    // R2 timer flag with enables off, R7 gating
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    rd(2'd0, v); chk("R2 timer flag", v, 8'h01);
    chk("R7 irq enables off", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h81);
    chk("R7 irq on", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h01);
    chk("R7 irq no gie", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h86);
    chk("R7 irq other source", {7'd0, irq}, 8'h00);

    // R6 clear and collision
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R6 clear", v, 8'h00);
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h00; tmr_ovf = 1'b1;
    tick(1);
    bus_wr = 1'b0; tmr_ovf = 1'b0;
    rd(2'd0, v); chk("R6 event wins", v, 8'h01);
    wr(2'd0, 8'h00);

    // R3 external pin edges
    edge_sel = 1'b1; ext_pin = 1'b1;
    tick(2); rd(2'd0, v); chk("R3 not yet", v, 8'h00);
    tick(1); rd(2'd0, v); chk("R3 rising", v, 8'h04);
    wr(2'd0, 8'h00);
    ext_pin = 1'b0; tick(4);
    rd(2'd0, v); chk("R3 falling ignored", v, 8'h00);
    edge_sel = 1'b0; tick(1);
    ext_pin = 1'b1; tick(4);
    rd(2'd0, v); chk("R3 rising ignored", v, 8'h00);
    ext_pin = 1'b0; tick(3);
    rd(2'd0, v); chk("R3 falling", v, 8'h04);
    wr(2'd0, 8'h00);

    // R4 port B mask
    wr(2'd2, 8'h10);
    pb_pins = 8'h08; tick(4);
    rd(2'd0, v); chk("R4 masked pin", v, 8'h00);
    pb_pins = 8'h18; tick(3);
    rd(2'd0, v); chk("R4 enabled pin", v, 8'h02);
    wr(2'd0, 8'h00);

    // R8 wake during sleep, gie off
    wr(2'd1, 8'h06);
    sleep_mode = 1'b1;
    pb_pins = 8'h08;
    tick(2); chk("R8 wake early", {7'd0, wake}, 8'h00);
    tick(1); chk("R8 wake pulse", {7'd0, wake}, 8'h01);
    rd(2'd0, v); chk("R8 flag with wake", v, 8'h02);
    chk("R7 irq low gie off", {7'd0, irq}, 8'h00);
    tick(1); chk("R8 wake one cycle", {7'd0, wake}, 8'h00);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h07);
    tmr_ovf = 1'b1; tick(1); tmr_ovf = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R8 timer no wake", {7'd0, wake}, 8'h00);
      tick(1);
    end
    sleep_mode = 1'b0;
    pb_pins = 8'h18;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk("R8 awake no pulse", {7'd0, wake}, 8'h00);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule